// File: doc/BRIEF.md
# Layer Pixel Address Generator

This block turns a pixel coordinate inside one of sixteen display layers into a physical memory location. Each layer has a descriptor that gives its base row in memory, its line width in pixels and a 4-bit pixel format code. The pixel format sets how many bits one pixel takes, always a power of two. A lookup takes a layer number and an X/Y coordinate. It returns the 32-bit memory word holding the first bit of that pixel, split into row, bank and column fields, plus the bit position of the pixel inside that word.

The descriptors are loaded through a plain write port that carries an index, the three field values and a strobe. Lookups use a valid/ready handshake and go through a two-stage pipeline. The first stage forms the line product Y × width. The second stage adds X, scales the result by the pixel size and adds the layer base. A layer whose format code is one of the undefined values gives an all-zero location and raises an error flag on its response.

Top module: `lyr_pix_addr`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1. Every descriptor reads as base 0, width 0 and format code 0x0.
- R2: For a layer with base B, width W and shift S, the pixel index is I = Y·W + X and the bit address is A = I·2^S. The 23-bit word address is (B·4096 + floor(A/32)) mod 2^23. `rsp_bit_off` equals A mod 32.
- R3: Format codes map to shifts as follows: 0x0→0, 0x1→1, 0x2→2, 0x3→3, 0x4, 0x5 and 0x7→4, and 0x6, 0x8, 0xE and 0xF→5.
- R4: Format codes 0x9 to 0xD are undefined. A response for such a layer has `rsp_err`=1, and its row, bank, column and bit offset are all 0. Any other code gives `rsp_err`=0.
- R5: The word address is split into row = bits [22:12], bank = bits [11:10] and column = bits [9:0].
- R6: The layer base holds only the row part of the address, so pixel (0,0) of any layer with a defined format has row = B, bank = 0, column = 0 and bit offset 0.
- R7: No limit applies to Y. The largest Y, X and width values are accepted without error, and the word address wraps modulo 2^23.
- R8: With `rsp_ready` held at 1, a request accepted in cycle n produces `rsp_valid`=1 in cycle n+2. Responses come out in request order.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the response fields hold steady into the next cycle and `req_ready` is 0.
- R10: A descriptor write in the same cycle as an accepted request for that entry does not affect that request. It affects the requests that follow.
- R11: Each of the sixteen descriptors is written and read on its own. A write to one entry leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 4 | Descriptor entry to write |
| wr_base | input | 11 | Layer base row |
| wr_dsz | input | 12 | Layer line width in pixels |
| wr_csc | input | 4 | Layer pixel format code |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle when valid |
| req_layer | input | 4 | Layer index of the lookup |
| req_x | input | 12 | Pixel X coordinate |
| req_y | input | 12 | Pixel Y coordinate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_row | output | 11 | Row field of the word address |
| rsp_bank | output | 2 | Bank field of the word address |
| rsp_col | output | 10 | Column field of the word address |
| rsp_bit_off | output | 5 | Starting bit of the pixel in the 32-bit word |
| rsp_err | output | 1 | Layer format code is undefined |

## Verification
The bench builds the block with its default parameters: 16 layers, 12-bit coordinates and widths, and an 11/2/10 split of the row, bank and column fields. At these sizes the bench can write every descriptor, so all sixteen format codes are covered, including each undefined one. The same sizes allow a corner where Y, X and the width are all at 4095 with a 32-bit format. That corner drives the scaled index far past 2^23 words, so the wrap of the word address is exercised. Random back-pressure on `rsp_ready` combines with descriptor rewrites during traffic to cover the pipeline hold behaviour and the rule that a same-cycle write takes effect only for later requests.

// File: rtl/lyr_pix_pkg.sv
package lyr_pix_pkg;

    localparam int WORD_BITS  = 32;
    localparam int WORD_LG2   = 5;
    localparam int CSC_W      = 4;
    localparam int SHIFT_W    = 3;
    localparam int MAX_SHIFT  = 5;

    typedef struct packed {
        logic               rsvd;
        logic [SHIFT_W-1:0] sh;
    } pix_fmt_t;

    function automatic pix_fmt_t csc_decode(input logic [CSC_W-1:0] code);
        pix_fmt_t f;
        f.rsvd = 1'b0;
        f.sh   = '0;
        case (code)
            4'h0: f.sh = 3'd0;
            4'h1: f.sh = 3'd1;
            4'h2: f.sh = 3'd2;
            4'h3: f.sh = 3'd3;
            4'h4, 4'h5, 4'h7: f.sh = 3'd4;
            4'h6, 4'h8, 4'hE, 4'hF: f.sh = 3'd5;
            default: f.rsvd = 1'b1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/lyr_desc_table.sv
module lyr_desc_table #(
    parameter int NUM_LAYERS = 16,
    parameter int ROW_W      = 11,
    parameter int DSZ_W      = 12,
    localparam int LAYER_W   = $clog2(NUM_LAYERS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [LAYER_W-1:0]             wr_idx,
    input  logic [ROW_W-1:0]               wr_base,
    input  logic [DSZ_W-1:0]               wr_dsz,
    input  logic [lyr_pix_pkg::CSC_W-1:0]  wr_csc,
    input  logic [LAYER_W-1:0]             rd_idx,
    output logic [ROW_W-1:0]               rd_base,
    output logic [DSZ_W-1:0]               rd_dsz,
    output logic [lyr_pix_pkg::CSC_W-1:0]  rd_csc
);
    logic [ROW_W-1:0]              base_q [NUM_LAYERS];
    logic [DSZ_W-1:0]              dsz_q  [NUM_LAYERS];
    logic [lyr_pix_pkg::CSC_W-1:0] csc_q  [NUM_LAYERS];

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g] <= '0;
                dsz_q[g]  <= '0;
                csc_q[g]  <= '0;
            end else if (wr_en && (wr_idx == LAYER_W'(g))) begin
                base_q[g] <= wr_base;
                dsz_q[g]  <= wr_dsz;
                csc_q[g]  <= wr_csc;
            end
        end
    end

    // Read sees the stored value: a write in this cycle lands after the lookup.
    assign rd_base = base_q[rd_idx];
    assign rd_dsz  = dsz_q[rd_idx];
    assign rd_csc  = csc_q[rd_idx];
endmodule

// File: rtl/lyr_addr_pipe.sv
module lyr_addr_pipe
    import lyr_pix_pkg::*;
#(
    parameter int X_W    = 12,
    parameter int Y_W    = 12,
    parameter int DSZ_W  = 12,
    parameter int ROW_W  = 11,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 in_v,
    input  logic [X_W-1:0]       in_x,
    input  logic [Y_W-1:0]       in_y,
    input  logic [ROW_W-1:0]     d_base,
    input  logic [DSZ_W-1:0]     d_dsz,
    input  logic [CSC_W-1:0]     d_csc,
    output logic                 out_v,
    output logic [ROW_W-1:0]     out_row,
    output logic [BANK_W-1:0]    out_bank,
    output logic [COL_W-1:0]     out_col,
    output logic [WORD_LG2-1:0]  out_off,
    output logic                 out_err
);
    localparam int PROD_W  = Y_W + DSZ_W;
    localparam int IDX_W   = ((PROD_W > X_W) ? PROD_W : X_W) + 1;
    localparam int BIT_W   = IDX_W + MAX_SHIFT;
    localparam int ROW_LSB = BANK_W + COL_W;
    localparam int WORD_W  = ROW_W + ROW_LSB;

    // Stage 1: descriptor capture and line product
    logic                s1_v;
    logic [PROD_W-1:0]   s1_prod;
    logic [X_W-1:0]      s1_x;
    logic [ROW_W-1:0]    s1_base;
    pix_fmt_t            s1_fmt;

    pix_fmt_t            fmt_d;
    logic [PROD_W-1:0]   prod_d;

    always_comb begin
        fmt_d  = csc_decode(d_csc);
        prod_d = {{DSZ_W{1'b0}}, in_y} * {{Y_W{1'b0}}, d_dsz};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v    <= 1'b0;
            s1_prod <= '0;
            s1_x    <= '0;
            s1_base <= '0;
            s1_fmt  <= '0;
        end else if (en) begin
            s1_v    <= in_v;
            s1_prod <= prod_d;
            s1_x    <= in_x;
            s1_base <= d_base;
            s1_fmt  <= fmt_d;
        end
    end

    // Stage 2: add X, scale to bits, split into word and bit offset
    logic [IDX_W-1:0]  idx;
    logic [BIT_W-1:0]  bit_addr;
    logic [BIT_W-1:0]  word_lin;
    logic [WORD_W-1:0] word_addr;

    always_comb begin
        idx       = IDX_W'(s1_prod) + IDX_W'(s1_x);
        bit_addr  = BIT_W'(idx) << s1_fmt.sh;
        word_lin  = bit_addr >> WORD_LG2;
        word_addr = word_lin[WORD_W-1:0] + {s1_base, {ROW_LSB{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v    <= 1'b0;
            out_row  <= '0;
            out_bank <= '0;
            out_col  <= '0;
            out_off  <= '0;
            out_err  <= 1'b0;
        end else if (en) begin
            out_v <= s1_v;
            if (s1_fmt.rsvd) begin
                out_row  <= '0;
                out_bank <= '0;
                out_col  <= '0;
                out_off  <= '0;
                out_err  <= 1'b1;
            end else begin
                out_row  <= word_addr[WORD_W-1:ROW_LSB];
                out_bank <= word_addr[ROW_LSB-1:COL_W];
                out_col  <= word_addr[COL_W-1:0];
                out_off  <= bit_addr[WORD_LG2-1:0];
                out_err  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lyr_pix_addr.sv
module lyr_pix_addr
    import lyr_pix_pkg::*;
#(
    parameter int NUM_LAYERS = 16,
    parameter int X_W        = 12,
    parameter int Y_W        = 12,
    parameter int DSZ_W      = 12,
    parameter int ROW_W      = 11,
    parameter int BANK_W     = 2,
    parameter int COL_W      = 10,
    localparam int LAYER_W   = $clog2(NUM_LAYERS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [LAYER_W-1:0]  wr_idx,
    input  logic [ROW_W-1:0]    wr_base,
    input  logic [DSZ_W-1:0]    wr_dsz,
    input  logic [CSC_W-1:0]    wr_csc,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LAYER_W-1:0]  req_layer,
    input  logic [X_W-1:0]      req_x,
    input  logic [Y_W-1:0]      req_y,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [ROW_W-1:0]    rsp_row,
    output logic [BANK_W-1:0]   rsp_bank,
    output logic [COL_W-1:0]    rsp_col,
    output logic [WORD_LG2-1:0] rsp_bit_off,
    output logic                rsp_err
);
    logic [ROW_W-1:0] d_base;
    logic [DSZ_W-1:0] d_dsz;
    logic [CSC_W-1:0] d_csc;
    logic             adv;

    // Whole pipeline moves together; it stalls only on a held response.
    assign adv       = !rsp_valid || rsp_ready;
    assign req_ready = adv;

    lyr_desc_table #(
        .NUM_LAYERS (NUM_LAYERS),
        .ROW_W      (ROW_W),
        .DSZ_W      (DSZ_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_base (wr_base),
        .wr_dsz  (wr_dsz),
        .wr_csc  (wr_csc),
        .rd_idx  (req_layer),
        .rd_base (d_base),
        .rd_dsz  (d_dsz),
        .rd_csc  (d_csc)
    );

    lyr_addr_pipe #(
        .X_W    (X_W),
        .Y_W    (Y_W),
        .DSZ_W  (DSZ_W),
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W),
        .COL_W  (COL_W)
    ) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .en       (adv),
        .in_v     (req_valid),
        .in_x     (req_x),
        .in_y     (req_y),
        .d_base   (d_base),
        .d_dsz    (d_dsz),
        .d_csc    (d_csc),
        .out_v    (rsp_valid),
        .out_row  (rsp_row),
        .out_bank (rsp_bank),
        .out_col  (rsp_col),
        .out_off  (rsp_bit_off),
        .out_err  (rsp_err)
    );
endmodule

// File: rtl/lyr_pix_addr_chk.sv
module lyr_pix_addr_chk #(
    parameter int ROW_W  = 11,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ROW_W-1:0]  rsp_row,
    input logic [BANK_W-1:0] rsp_bank,
    input logic [COL_W-1:0]  rsp_col,
    input logic [4:0]        rsp_bit_off,
    input logic              rsp_err
);
    p_rst_idle_r1: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |->
            (rsp_row == '0 && rsp_bank == '0 && rsp_col == '0 && rsp_bit_off == '0));

    p_two_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> ##1 rsp_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_row) && $stable(rsp_bank) && $stable(rsp_col)
             && $stable(rsp_bit_off) && $stable(rsp_err)));

    p_stall_in_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind lyr_pix_addr lyr_pix_addr_chk #(
    .ROW_W  (ROW_W),
    .BANK_W (BANK_W),
    .COL_W  (COL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_row     (rsp_row),
    .rsp_bank    (rsp_bank),
    .rsp_col     (rsp_col),
    .rsp_bit_off (rsp_bit_off),
    .rsp_err     (rsp_err)
);

// File: tb/lyr_pix_addr_tb.sv
`timescale 1ns/1ps
module lyr_pix_addr_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [10:0] wr_base = '0;
    logic [11:0] wr_dsz = '0;
    logic [3:0]  wr_csc = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_layer = '0;
    logic [11:0] req_x = '0;
    logic [11:0] req_y = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [10:0] rsp_row;
    logic [1:0]  rsp_bank;
    logic [9:0]  rsp_col;
    logic [4:0]  rsp_bit_off;
    logic        rsp_err;

    always #2 clk = ~clk;

    lyr_pix_addr u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_dsz(wr_dsz), .wr_csc(wr_csc), .req_valid(req_valid), .req_ready(req_ready),
        .req_layer(req_layer), .req_x(req_x), .req_y(req_y), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_row(rsp_row), .rsp_bank(rsp_bank), .rsp_col(rsp_col),
        .rsp_bit_off(rsp_bit_off), .rsp_err(rsp_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit bp_en = 0;
    string cur_tag = "R2";

    logic [10:0] m_base [16];
    logic [11:0] m_dsz  [16];
    logic [3:0]  m_csc  [16];
    logic [28:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, expv, $time);
        end
    endtask

    // Reference: {err, word[22:0], bit_off[4:0]}
    function automatic logic [28:0] exp_f(input int lay, input int x, input int y);
        int sh;
        bit bad;
        longint li, ba, w;
        bad = 0;
        case (m_csc[lay])
            4'h0: sh = 0;
            4'h1: sh = 1;
            4'h2: sh = 2;
            4'h3: sh = 3;
            4'h4, 4'h5, 4'h7: sh = 4;
            4'h6, 4'h8, 4'hE, 4'hF: sh = 5;
            default: begin sh = 0; bad = 1; end
        endcase
        if (bad) return {1'b1, 28'd0};
        li = longint'(y) * longint'(m_dsz[lay]) + longint'(x);
        ba = li << sh;
        w  = ((ba >>> 5) + (longint'(m_base[lay]) << 12)) & 64'h7FFFFF;
        return {1'b0, w[22:0], ba[4:0]};
    endfunction

    logic [28:0] act_v, prev_act;
    bit          prev_hold = 0;
    always_comb act_v = {rsp_err, rsp_row, rsp_bank, rsp_col, rsp_bit_off};

    // Monitor at the falling edge: scoreboard, hold check, model update.
    always @(negedge clk) begin
        if (rst) begin
            prev_hold = 0;
        end else begin
            if (prev_hold) begin
                chk(rsp_valid && act_v == prev_act, "R9 hold", {3'b0, act_v}, {3'b0, prev_act});
            end
            if (rsp_valid && !rsp_ready)
                chk(!req_ready, "R9 req_ready", {31'b0, req_ready}, 32'd0);
            if (rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected response", {3'b0, act_v}, 32'd0);
                end else begin
                    logic [28:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(act_v == e, t, {3'b0, act_v}, {3'b0, e});
                end
            end
            if (req_valid && req_ready) begin
                exp_q.push_back(exp_f(req_layer, req_x, req_y));
                tag_q.push_back(cur_tag);
            end
            if (wr_en) begin
                m_base[wr_idx] = wr_base;
                m_dsz[wr_idx]  = wr_dsz;
                m_csc[wr_idx]  = wr_csc;
            end
            prev_hold = rsp_valid && !rsp_ready;
            prev_act  = act_v;
        end
    end

    always @(posedge clk) begin
        #1 rsp_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
    end

    task automatic wr_desc(input int idx, input int base, input int dsz, input int csc);
        @(posedge clk); #1;
        wr_en = 1; wr_idx = 4'(idx); wr_base = 11'(base); wr_dsz = 12'(dsz); wr_csc = 4'(csc);
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic send(input int lay, input int x, input int y, input string tag);
        cur_tag = tag;
        req_valid = 1; req_layer = 4'(lay); req_x = 12'(x); req_y = 12'(y);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(posedge clk); guard++;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog R8 act=%0d exp=0 pending", exp_q.size());
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hA5C3));
        for (int i = 0; i < 16; i++) begin m_base[i] = '0; m_dsz[i] = '0; m_csc[i] = '0; end
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        chk(!rsp_valid, "R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        @(posedge clk); #1 rst = 0;
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R1 idle after reset", {30'b0, rsp_valid, req_ready}, 32'd1);
        @(posedge clk); #1;

        // R1: untouched descriptor behaves as base 0, width 0, code 0
        send(5, 100, 7, "R1 zero descriptor");
        drain();

        // R3 R4 R11: one code per entry, each entry distinct
        for (int i = 0; i < 16; i++) wr_desc(i, (i * 113 + 3) % 2048, 37 + i * 61, i);
        for (int i = 0; i < 16; i++) send(i, 3 * i + 1, 2 + i, (i >= 9 && i <= 13) ? "R4 reserved code" : "R3 code shift");
        drain();
        // R11: rewrite entry 4 only, then read entries 3, 4, 5
        wr_desc(4, 555, 640, 3);
        send(3, 10, 10, "R11 neighbour below");
        send(4, 10, 10, "R11 rewritten entry");
        send(5, 10, 10, "R11 neighbour above");
        drain();

        // R7 R5: maximal coordinates and width, 32-bit pixels, top base row
        wr_desc(2, 2047, 4095, 6);
        send(2, 4095, 4095, "R7 max Y wrap");
        send(2, 31, 4095, "R5 field split");
        // R6: origin pixel lands on the base row boundary
        wr_desc(9, 1234, 800, 15);
        send(9, 0, 0, "R6 origin");
        wr_desc(1, 77, 320, 4);
        send(1, 0, 0, "R6 origin 16bpp");
        send(1, 319, 239, "R2 last pixel");
        drain();

        // R8: exact latency with no back-pressure
        @(posedge clk); #1;
        cur_tag = "R8 latency";
        req_valid = 1; req_layer = 4'd1; req_x = 12'd5; req_y = 12'd6;
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R8 cycle 0", {30'b0, rsp_valid, req_ready}, 32'd1);
        @(posedge clk); #1 req_valid = 0;
        @(negedge clk);
        chk(!rsp_valid, "R8 cycle 1", {31'b0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk(rsp_valid, "R8 cycle 2", {31'b0, rsp_valid}, 32'd1);
        drain();

        // R10: write and lookup of the same entry in one cycle
        wr_desc(7, 100, 50, 3);
        @(posedge clk); #1;
        cur_tag = "R10 same-cycle write";
        wr_en = 1; wr_idx = 4'd7; wr_base = 11'd900; wr_dsz = 12'd9; wr_csc = 4'h0;
        req_valid = 1; req_layer = 4'd7; req_x = 12'd40; req_y = 12'd3;
        @(negedge clk);
        @(posedge clk); #1;
        wr_en = 0; req_valid = 0;
        send(7, 40, 3, "R10 following request");
        drain();

        // Random traffic with back-pressure and interleaved rewrites
        bp_en = 1;
        for (int n = 0; n < 500; n++) begin
            if (($urandom % 8) == 0)
                wr_desc($urandom % 16, $urandom % 2048, $urandom % 4096, $urandom % 16);
            else
                send($urandom % 16, $urandom % 4096, $urandom % 4096, "R2 random");
        end
        bp_en = 0;
        drain();
        chk(exp_q.size() == 0, "R8 all responses returned", exp_q.size(), 32'd0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule